// File: doc/BRIEF.md
# Four-Phase CCD Array Clock Sequencer

This block drives the clocks of a serial-parallel-serial charge-coupled sampling array from a fast master clock. Each sample starts with a sample gate on one of two input channels. The four fast serial-register phases then step the captured charge along in make-before-break fashion: a phase rises while its predecessor is still high, and the predecessor drops one master cycle later. After sixteen samples the sequencer stops stepping the serial phases for one step and issues a parallel transfer pulse. That pulse moves the whole serial register into the parallel registers.

The parallel registers have their own four overlapping phases. These advance one step for every four samples, so a full slow cycle spans one batch of sixteen samples. A separately registered copy of slow phase 1 is provided for an external time base that counts acquired samples.

The sequencer only runs in fast-in slow-out operation. When the mode input selects the short-pipe mode, or when enable is low, no new sample starts. A sample already under way is completed, and the fast outputs then rest low. The batch position is kept while idle, so a resumed run completes the same batch.

Top module: `ccd_phase_seq`

## Requirements
- R1: While rst_n is low, every output is low. The first batch after reset contains exactly SAMPLES sample gates before its transfer pulse.
- R2: At most one sample gate is high at a time. The gate used for a sample is gate_c0 when ch_sel was 0 at the start of that sample and gate_c1 when it was 1. A change of ch_sel during a gate does not affect that gate.
- R3: A-phase 1 rises while the sample gate is high. The gate falls one cycle later, with A-phase 1 still high.
- R4: Each of A-phases 2, 3 and 4 rises while the preceding phase is high, and that preceding phase falls one cycle later. At the start of a batch or after idle, A-phase 4 may instead rise together with the sample gate.
- R5: At most two A-phases are high at once, and two high phases are always adjacent in the cyclic order.
- R6: A sample gate lasts STEP_CYC cycles and A-phase 1 lasts STEP_CYC+1 cycles (one step plus one overlap cycle).
- R7: The transfer pulse rises once every SAMPLES sample gates and lasts STEP_CYC cycles. All A-phases and both gates are low while it is high.
- R8: With the run conditions held, the next sample gate rises in the first cycle after the transfer pulse falls.
- R9: The B-phases advance one step per SAMPLES/4 samples in the order 1, 2, 3, 4, 1, each rising while its predecessor is high. At most two are high at once, B-phase 1 rises once per batch, and B-phase 4 alone is high during a transfer.
- R10: b1_tb equals B-phase 1 in every cycle.
- R11: After en falls, the sample under way runs to the end of its A-phase 3 step. A pending transfer is also completed. All A-phases and gates then stay low.
- R12: While pipe_mode is 1, no sample starts even with en high.
- R13: From idle, with en high and pipe_mode 0 sampled on a clock edge, the sample gate and A-phase 4 are high after the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low asynchronous reset, released synchronously |
| en | input | 1 | Run enable |
| ch_sel | input | 1 | Channel select, sampled at the start of each sample |
| pipe_mode | input | 1 | 0: fast-in slow-out runs; 1: short-pipe, sequencing held off |
| gate_c0 | output | 1 | Sample gate, channel 0 |
| gate_c1 | output | 1 | Sample gate, channel 1 |
| a_ph | output | 4 | Fast serial-register phases, bit 0 = phase 1 |
| xfer | output | 1 | Serial-to-parallel transfer pulse |
| b_ph | output | 4 | Slow parallel-register phases, bit 0 = phase 1 |
| b1_tb | output | 1 | Registered copy of B-phase 1 for the time base |

## Verification
Two events can land on the same master cycle. The first pair is the end of a transfer and the rising sample gate of the next batch. It appears whenever enable stays high across a transfer, and it is judged by the gate being high in the cycle right after the pulse falls. The second pair is a slow-phase handoff and the gate-to-phase-1 overlap, because every fourth sample completion advances the B clock. It appears in every full batch, and it is judged by the adjacency, ordering and B4-at-transfer checks running alongside the fast-phase overlap checks. Enable is also dropped in the middle of a batch, to show that the batch position survives the stop.

// File: rtl/ccdseq_pkg.sv
package ccdseq_pkg;

  // Slot of the fast sample cycle. LOAD carries the sample gate and A-phase 4.
  typedef enum logic [2:0] {
    SL_IDLE = 3'd0,
    SL_LOAD = 3'd1,
    SL_PH1  = 3'd2,
    SL_PH2  = 3'd3,
    SL_PH3  = 3'd4,
    SL_XFER = 3'd5
  } slot_e;

  localparam int NUM_PH = 4;

endpackage

// File: rtl/ccd_a_timer.sv
module ccd_a_timer
  import ccdseq_pkg::*;
#(
  parameter int STEP_CYC = 4,
  parameter int SAMPLES  = 16
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  run_ok,
  input  logic  ch_sel,
  output slot_e slot,
  output logic  last,
  output logic  cont,
  output logic  chan,
  output logic  smp_evt
);

  localparam int SW = (STEP_CYC > 1) ? $clog2(STEP_CYC) : 1;
  localparam int CW = $clog2(SAMPLES + 1);
  localparam logic [SW-1:0] STEP_LAST = SW'(STEP_CYC - 1);
  localparam logic [CW-1:0] CNT_FULL  = CW'(SAMPLES);

  slot_e          slot_q, slot_d;
  logic [SW-1:0]  step_q, step_d;
  logic [CW-1:0]  cnt_q, cnt_d;
  logic           chan_q, chan_d;
  logic           full;

  assign last    = (step_q == STEP_LAST);
  assign full    = (cnt_q == CNT_FULL);
  assign cont    = run_ok && !full;
  assign smp_evt = (slot_q == SL_LOAD) && last;
  assign slot    = slot_q;
  assign chan    = chan_q;

  // next-state logic
  always_comb begin
    slot_d = slot_q;
    cnt_d  = cnt_q;
    chan_d = chan_q;
    if (slot_q == SL_IDLE) begin
      step_d = '0;
    end else begin
      step_d = last ? '0 : step_q + 1'b1;
    end
    unique case (slot_q)
      SL_IDLE: begin
        if (run_ok) begin
          slot_d = SL_LOAD;
          chan_d = ch_sel;
        end
      end
      SL_LOAD: begin
        if (last) begin
          slot_d = SL_PH1;
          cnt_d  = cnt_q + 1'b1;
        end
      end
      SL_PH1: if (last) slot_d = SL_PH2;
      SL_PH2: if (last) slot_d = SL_PH3;
      SL_PH3: begin
        if (last) begin
          if (full) begin
            slot_d = SL_XFER;
            cnt_d  = '0;
          end else if (run_ok) begin
            slot_d = SL_LOAD;
            chan_d = ch_sel;
          end else begin
            slot_d = SL_IDLE;
          end
        end
      end
      SL_XFER: begin
        if (last) begin
          if (run_ok) begin
            slot_d = SL_LOAD;
            chan_d = ch_sel;
          end else begin
            slot_d = SL_IDLE;
          end
        end
      end
      default: slot_d = SL_IDLE;
    endcase
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q <= SL_IDLE;
      step_q <= '0;
      cnt_q  <= '0;
      chan_q <= 1'b0;
    end else begin
      slot_q <= slot_d;
      step_q <= step_d;
      cnt_q  <= cnt_d;
      chan_q <= chan_d;
    end
  end

endmodule

// File: rtl/ccd_a_decode.sv
module ccd_a_decode
  import ccdseq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  slot_e             slot,
  input  logic              last,
  input  logic              cont,
  input  logic              chan,
  output logic              gate_c0,
  output logic              gate_c1,
  output logic [NUM_PH-1:0] a_ph,
  output logic              xfer
);

  logic [NUM_PH-1:0] ph_n;
  logic              ld, g0_n, g1_n, x_n;

  // phase k+1 rises in the last cycle of slot k (one-cycle overlap)
  always_comb begin
    ld      = (slot == SL_LOAD);
    ph_n[0] = (slot == SL_PH1) || (ld && last);
    ph_n[1] = (slot == SL_PH2) || ((slot == SL_PH1) && last);
    ph_n[2] = (slot == SL_PH3) || ((slot == SL_PH2) && last);
    ph_n[3] = ld || ((slot == SL_PH3) && last && cont);
    g0_n    = ld && !chan;
    g1_n    = ld && chan;
    x_n     = (slot == SL_XFER);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_ph    <= '0;
      gate_c0 <= 1'b0;
      gate_c1 <= 1'b0;
      xfer    <= 1'b0;
    end else begin
      a_ph    <= ph_n;
      gate_c0 <= g0_n;
      gate_c1 <= g1_n;
      xfer    <= x_n;
    end
  end

endmodule

// File: rtl/ccd_b_clock.sv
module ccd_b_clock
  import ccdseq_pkg::*;
#(
  parameter int SAMPLES = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_evt,
  output logic [NUM_PH-1:0] b_ph,
  output logic              b1_copy
);

  localparam int SPB = SAMPLES / NUM_PH;
  localparam int SBW = (SPB > 1) ? $clog2(SPB) : 1;
  localparam int IW  = $clog2(NUM_PH);
  localparam logic [SBW-1:0] SUB_LAST = SBW'(SPB - 1);

  logic [SBW-1:0]    sub_q, sub_d;
  logic [IW-1:0]     idx_q, idx_d;
  logic              on_q, on_d;
  logic              tick;
  logic [NUM_PH-1:0] ph_n;

  assign tick = smp_evt && (sub_q == SUB_LAST);

  // next-state logic
  always_comb begin
    sub_d = sub_q;
    idx_d = idx_q;
    on_d  = on_q || tick;
    if (smp_evt) begin
      sub_d = (sub_q == SUB_LAST) ? '0 : sub_q + 1'b1;
    end
    if (tick) begin
      idx_d = on_q ? idx_q + 1'b1 : '0;
    end
  end

  // next phase rises on the tick cycle, old phase falls a cycle later
  for (genvar k = 0; k < NUM_PH; k++) begin : g_bph
    assign ph_n[k] = (on_q && (idx_q == IW'(k))) || (tick && (idx_d == IW'(k)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sub_q   <= '0;
      idx_q   <= '0;
      on_q    <= 1'b0;
      b_ph    <= '0;
      b1_copy <= 1'b0;
    end else begin
      sub_q   <= sub_d;
      idx_q   <= idx_d;
      on_q    <= on_d;
      b_ph    <= ph_n;
      b1_copy <= ph_n[0];
    end
  end

endmodule

// File: rtl/ccd_phase_seq.sv
module ccd_phase_seq
  import ccdseq_pkg::*;
#(
  parameter int STEP_CYC = 4,
  parameter int SAMPLES  = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       ch_sel,
  input  logic       pipe_mode,
  output logic       gate_c0,
  output logic       gate_c1,
  output logic [3:0] a_ph,
  output logic       xfer,
  output logic [3:0] b_ph,
  output logic       b1_tb
);

  slot_e slot;
  logic  last, cont, chan, smp_evt, run_ok;

  assign run_ok = en && !pipe_mode;

  ccd_a_timer #(
    .STEP_CYC (STEP_CYC),
    .SAMPLES  (SAMPLES)
  ) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .run_ok  (run_ok),
    .ch_sel  (ch_sel),
    .slot    (slot),
    .last    (last),
    .cont    (cont),
    .chan    (chan),
    .smp_evt (smp_evt)
  );

  ccd_a_decode u_adec (
    .clk     (clk),
    .rst_n   (rst_n),
    .slot    (slot),
    .last    (last),
    .cont    (cont),
    .chan    (chan),
    .gate_c0 (gate_c0),
    .gate_c1 (gate_c1),
    .a_ph    (a_ph),
    .xfer    (xfer)
  );

  ccd_b_clock #(
    .SAMPLES (SAMPLES)
  ) u_bclk (
    .clk     (clk),
    .rst_n   (rst_n),
    .smp_evt (smp_evt),
    .b_ph    (b_ph),
    .b1_copy (b1_tb)
  );

endmodule

// File: rtl/ccd_phase_seq_chk.sv
module ccd_phase_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       gate_c0,
  input logic       gate_c1,
  input logic [3:0] a_ph,
  input logic       xfer,
  input logic [3:0] b_ph,
  input logic       b1_tb
);

  logic gate_any;
  assign gate_any = gate_c0 || gate_c1;

  // R2
  gates_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate_c0 && gate_c1));

  // R3
  a1_in_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(a_ph[0]) |-> gate_any);

  // R3
  gate_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(gate_any) |-> (a_ph[0] && $past(a_ph[0])));

  // R4
  a2_over_a1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(a_ph[1]) |-> a_ph[0]);

  // R4
  a1_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(a_ph[0]) |-> $past(a_ph[1]));

  // R4
  a3_over_a2_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(a_ph[2]) |-> a_ph[1]);

  // R5
  adj_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(a_ph) <= 2) && !(a_ph[0] && a_ph[2]) && !(a_ph[1] && a_ph[3]));

  // R7
  xfer_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer |-> ((a_ph == 4'b0000) && !gate_any));

  // R9
  b_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(b_ph) <= 2);

  // R10
  b1_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    b1_tb == b_ph[0]);

endmodule

bind ccd_phase_seq ccd_phase_seq_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .gate_c0 (gate_c0),
  .gate_c1 (gate_c1),
  .a_ph    (a_ph),
  .xfer    (xfer),
  .b_ph    (b_ph),
  .b1_tb   (b1_tb)
);

// File: tb/tb_ccd_phase_seq.sv
`timescale 1ns/1ps
module tb_ccd_phase_seq;

  localparam int STEP = 4;
  localparam int NSMP = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic       ch_sel = 1'b0;
  logic       pipe_mode = 1'b0;
  logic       gate_c0, gate_c1, xfer, b1_tb;
  logic [3:0] a_ph, b_ph;

  int n_chk = 0;
  int n_fail = 0;

  ccd_phase_seq #(.STEP_CYC(STEP), .SAMPLES(NSMP)) dut (
    .clk(clk), .rst_n(rst_n), .en(en), .ch_sel(ch_sel), .pipe_mode(pipe_mode),
    .gate_c0(gate_c0), .gate_c1(gate_c1), .a_ph(a_ph), .xfer(xfer),
    .b_ph(b_ph), .b1_tb(b1_tb)
  );

  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // ---------------- monitor ----------------
  logic [3:0] a_pv = '0, b_pv = '0;
  logic       g_pv = 1'b0, x_pv = 1'b0;
  int gcnt = 0, grun = 0, a1run = 0, xrun = 0, n_xfer = 0, b1_rises = 0;
  int v_r2 = 0, v_r5 = 0, v_r7 = 0, v_r9 = 0, v_r10 = 0;
  int en_hold = 0;

  always @(posedge clk) en_hold <= (en && !pipe_mode) ? en_hold + 1 : 0;

  always @(negedge clk) begin
    logic g;
    g = gate_c0 || gate_c1;
    if (!rst_n) begin
      a_pv = '0; b_pv = '0; g_pv = 1'b0; x_pv = 1'b0;
      gcnt = 0; grun = 0; a1run = 0; xrun = 0;
    end else begin
      if (gate_c0 && gate_c1) v_r2++;
      if ($countones(a_ph) > 2 || (a_ph[0] && a_ph[2]) || (a_ph[1] && a_ph[3])) v_r5++;
      if (xfer && (a_ph != 4'b0 || g)) v_r7++;
      if ($countones(b_ph) > 2) v_r9++;
      if (b1_tb !== b_ph[0]) v_r10++;
      if (g && !g_pv) gcnt++;
      if (!g && g_pv) begin
        chk(a_ph[0] && a_pv[0], "R3 gate falls under A-phase 1", int'(a_ph[0]), 1);
        chk(grun == STEP, "R6 gate width", grun, STEP);
      end
      grun = g ? grun + 1 : 0;
      if (a_ph[0] && !a_pv[0]) chk(g, "R3 A-phase 1 rises inside gate", int'(g), 1);
      if (a_ph[1] && !a_pv[1]) chk(a_ph[0], "R4 A-phase 2 over phase 1", int'(a_ph[0]), 1);
      if (a_ph[2] && !a_pv[2]) chk(a_ph[1], "R4 A-phase 3 over phase 2", int'(a_ph[1]), 1);
      if (a_ph[3] && !a_pv[3]) chk(a_ph[2] || (g && !g_pv), "R4 A-phase 4 over phase 3", int'(a_ph[2]), 1);
      if (!a_ph[0] && a_pv[0]) begin
        chk(a_ph[1], "R4 A-phase 1 falls after phase 2 up", int'(a_ph[1]), 1);
        chk(a1run == STEP + 1, "R6 A-phase 1 width", a1run, STEP + 1);
      end
      a1run = a_ph[0] ? a1run + 1 : 0;
      if (xfer && !x_pv) begin
        chk(gcnt == NSMP, "R7 gates per transfer", gcnt, NSMP);
        chk(b_ph == 4'b1000, "R9 B-phase 4 alone at transfer", int'(b_ph), 8);
        gcnt = 0;
        n_xfer++;
      end
      if (!xfer && x_pv) begin
        chk(xrun == STEP, "R7 transfer width", xrun, STEP);
        if (en_hold >= 4) chk(g, "R8 gate right after transfer", int'(g), 1);
      end
      xrun = xfer ? xrun + 1 : 0;
      for (int k = 1; k < 4; k++) begin
        if (b_ph[k] && !b_pv[k]) chk(b_ph[k-1], "R9 B-phase rises over predecessor", int'(b_ph), k);
      end
      if (b_ph[0] && !b_pv[0]) begin
        chk(b_ph[3] || (b_pv == 4'b0), "R9 B-phase 1 over phase 4", int'(b_ph), 9);
        b1_rises++;
      end
      a_pv = a_ph; b_pv = b_ph; g_pv = g; x_pv = xfer;
    end
  end

  // ---------------- scenarios ----------------
  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk({gate_c0, gate_c1, a_ph, xfer, b_ph, b1_tb} == '0, "R1 outputs low in reset",
        int'({gate_c0, gate_c1, a_ph, xfer, b_ph, b1_tb}), 0);
    rst_n = 1'b1;
    repeat (20) @(negedge clk);
    chk({gate_c0, gate_c1, a_ph, xfer, b_ph} == '0, "R11 idle without enable",
        int'({gate_c0, gate_c1, a_ph, xfer, b_ph}), 0);
  endtask

  task automatic t_start(input logic ch);
    int i;
    ch_sel = ch;
    en = 1'b1;
    for (i = 1; i <= 5; i++) begin
      @(negedge clk);
      if (gate_c0 || gate_c1) break;
    end
    chk(i == 2, "R13 start latency", i, 2);
    chk(ch ? (gate_c1 && !gate_c0) : (gate_c0 && !gate_c1), "R2 gate of selected channel",
        int'({gate_c1, gate_c0}), ch ? 2 : 1);
    chk(a_ph == 4'b1000, "R13 A-phase 4 with first gate", int'(a_ph), 8);
  endtask

  task automatic t_batch();
    int x0, b0;
    x0 = n_xfer;
    b0 = b1_rises;
    while (n_xfer == x0) @(negedge clk);
    chk(b1_rises - b0 == 1, "R9 one B-phase 1 pulse per batch", b1_rises - b0, 1);
  endtask

  task automatic t_chan_latch(input logic ch);
    ch_sel = ch;
    while (gate_c0 || gate_c1) @(negedge clk);
    while (!(gate_c0 || gate_c1)) @(negedge clk);
    ch_sel = !ch;
    repeat (2) @(negedge clk);
    chk(ch ? (gate_c1 && !gate_c0) : (gate_c0 && !gate_c1), "R2 gate held despite select change",
        int'({gate_c1, gate_c0}), ch ? 2 : 1);
    while (gate_c0 || gate_c1) @(negedge clk);
    while (!(gate_c0 || gate_c1)) @(negedge clk);
    chk(ch ? (gate_c0 && !gate_c1) : (gate_c1 && !gate_c0), "R2 next gate follows new select",
        int'({gate_c1, gate_c0}), ch ? 1 : 2);
  endtask

  task automatic t_stop();
    int gsnap;
    while (!a_ph[1]) @(negedge clk);
    en = 1'b0;
    repeat (4 * STEP + 4) @(negedge clk);
    chk({gate_c0, gate_c1, a_ph} == '0, "R11 stop after current sample",
        int'({gate_c0, gate_c1, a_ph}), 0);
    gsnap = gcnt;
    repeat (30) @(negedge clk);
    chk(gcnt == gsnap && {gate_c0, gate_c1, a_ph} == '0, "R11 stays idle", gcnt, gsnap);
    en = 1'b1;
  endtask

  task automatic t_mode();
    int seen;
    en = 1'b0;
    repeat (30) @(negedge clk);
    pipe_mode = 1'b1;
    en = 1'b1;
    seen = 0;
    repeat (40) begin
      @(negedge clk);
      if (gate_c0 || gate_c1 || a_ph != 4'b0) seen++;
    end
    chk(seen == 0, "R12 short-pipe mode holds off", seen, 0);
    pipe_mode = 1'b0;
    seen = 0;
    for (int i = 1; i <= 5; i++) begin
      @(negedge clk);
      if (gate_c0 || gate_c1) begin
        seen = i;
        break;
      end
    end
    chk(seen == 2, "R13 start after mode release", seen, 2);
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    t_reset();
    t_start(1'b0);
    t_batch();          // R1: first batch after reset holds NSMP gates
    t_batch();
    t_chan_latch(1'b1);
    t_batch();
    t_stop();
    t_batch();
    t_mode();
    t_batch();
    repeat (5) @(negedge clk);
    chk(v_r2 == 0, "R2 gates never overlap", v_r2, 0);
    chk(v_r5 == 0, "R5 only adjacent phase pairs", v_r5, 0);
    chk(v_r7 == 0, "R7 phases quiet during transfer", v_r7, 0);
    chk(v_r9 == 0, "R9 at most two B-phases", v_r9, 0);
    chk(v_r10 == 0, "R10 time-base copy matches", v_r10, 0);
    report();
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

endmodule